// File: doc/BRIEF.md
# Shutdown and Suspend Power Controller

This block decides, every reference-clock cycle, which PLLs run and which clock output drivers are enabled in a multi-PLL clock generator. Three things feed the decision. The first is an active-low shutdown/output-enable pin. The second is an active-low suspend pin that applies a programmable set of PLL and output masks. The third is a set of per-resource disable bits that software writes through a small configuration port. The block also receives the output routing map, which tells it which PLL, or the reference, drives each output. Because of this map, stopping a PLL always takes down every output fed by that PLL.

The shutdown pin always turns the output drivers off. When the system-shutdown control bit is set, the shutdown pin also stops the PLLs, the output divider counters and the reference oscillator. A PLL that starts running again must relock before it is used. Its ready flag, and the enables of the outputs it feeds, stay low for a programmable number of reference cycles after the restart. If the suspend masks stop a PLL but leave one of its dependent outputs unmasked, the block turns that output off anyway and raises a sticky error flag.

The configuration port is a write-only valid/ready channel. `cfg_ready` is held high at all times, including during shutdown, so a write completes on any cycle in which `cfg_valid` is high and the port never applies back-pressure. All inputs are assumed to be synchronous to `clk`.

Top module: `pwr_suspend_ctrl`

## Requirements
- R1: One clock edge after `shdn_oe_n` is sampled low, every bit of `out_oe` is 0, whatever the state of the system-shutdown bit.
- R2: When control register bit 0 (address 0, system shutdown) is 1 and `shdn_oe_n` is sampled low, `pll_en`, `pll_ready`, `osc_en` and `div_en` are all 0 after the next edge.
- R3: When control bit 0 is 0, a low `shdn_oe_n` does not change `pll_en`, `pll_ready`, `osc_en` or `div_en`.
- R4: While `susp_n` is low, a PLL whose bit is set in the suspend-PLL mask (address 3) and an output whose bit is set in the suspend-output mask (address 4) are disabled. While `susp_n` is high, the two masks have no effect.
- R5: Each output's 2-bit route field in `route_sel` (bits 2o+1:2o) selects its source: code 0 selects the reference, and code k (1 to 3) selects PLL k-1. An output whose selected PLL is not ready has `out_oe` at 0, even when none of its own disable or suspend bits is set.
- R6: Setting a bit in the PLL disable register (address 1) stops that PLL. Setting a bit in the output disable register (address 2) turns that output off. Both take effect regardless of the two pins.
- R7: `cfg_ready` is always 1, including while `shdn_oe_n` is low. A write is captured at the edge on which `cfg_valid` is high, and it affects the outputs from the following edge.
- R8: When a PLL starts, `pll_en` rises after one edge, and `pll_ready` rises N edges after `pll_en` rises, where N is the relock count register (address 5, reset value 8). When N is 0, `pll_ready` rises on the same edge as `pll_en`. The outputs fed by that PLL stay off until its `pll_ready` is 1.
- R9: `mask_err` goes to 1 one edge after a cycle in which `susp_n` is low, a PLL is suspend-masked, and an output routed to that PLL is not suspend-masked. It then stays at 1 until a write to address 0 with bit 1 set. If a set and a clear occur in the same cycle, the set wins.
- R10: An output routed to the reference (code 0) is enabled whenever `shdn_oe_n` is high and neither its disable bit nor its active suspend bit is set. No PLL state affects it.
- R11: While `rst_n` is low, `pll_en`, `pll_ready`, `out_oe`, `osc_en`, `div_en` and `mask_err` are all 0. The relock count resets to 8 and all other configuration bits reset to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Active-low synchronous reset |
| shdn_oe_n | input | 1 | Active-low shutdown / output-enable pin |
| susp_n | input | 1 | Active-low suspend pin |
| route_sel | input | NUM_OUT*SRC_W (8) | Per-output source code: 0 selects the reference, k selects PLL k-1 |
| cfg_valid | input | 1 | Configuration write valid |
| cfg_ready | output | 1 | Configuration write ready (always 1) |
| cfg_addr | input | ADDR_W (3) | Configuration register address |
| cfg_wdata | input | DATA_W (16) | Configuration write data |
| pll_en | output | NUM_PLL (3) | Per-PLL run enable |
| pll_ready | output | NUM_PLL (3) | Per-PLL lock-ready flag |
| out_oe | output | NUM_OUT (4) | Per-output driver enable (0 means high impedance) |
| osc_en | output | 1 | Reference oscillator enable |
| div_en | output | 1 | Output divider counter enable |
| mask_err | output | 1 | Sticky flag for an inconsistent suspend mask |

## Verification
The bench runs a behavioural model alongside the design and compares every output on every cycle. It targets several corner cases.
- PLL restart with relock counts of 3 and 0. An off-by-one relock counter would release `pll_ready` and the dependent outputs one edge early or late.
- Shutdown with the system-shutdown bit both clear and set. A design that confused the two modes would stop the PLLs on a plain output-enable, or leave the oscillator running in full shutdown.
- An inconsistent suspend mask. A design without the dependency rule would leave an output enabled while its PLL is stopped, and a non-sticky flag would drop when suspend is released.
- A clear write that arrives in the same cycle as a new error. A design where the clear wins would read 0.
- An output moved onto a suspended PLL while suspend is active. A design that ignored the routing map would leave that output enabled.

// File: rtl/pwr_ctl_pkg.sv
package pwr_ctl_pkg;

  // Configuration register addresses
  localparam int unsigned ADR_CTRL     = 0;
  localparam int unsigned ADR_PLL_OFF  = 1;
  localparam int unsigned ADR_OUT_OFF  = 2;
  localparam int unsigned ADR_SUSP_PLL = 3;
  localparam int unsigned ADR_SUSP_OUT = 4;
  localparam int unsigned ADR_RELOCK   = 5;

  // Control register bit positions
  localparam int unsigned CTRL_SYSDOWN = 0;
  localparam int unsigned CTRL_ERRCLR  = 1;

  typedef enum logic [1:0] {
    LK_OFF   = 2'd0,
    LK_WAIT  = 2'd1,
    LK_READY = 2'd2
  } lock_state_e;

endpackage

// File: rtl/pwr_cfg_regs.sv
module pwr_cfg_regs
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned NUM_PLL    = 3,
  parameter int unsigned NUM_OUT    = 4,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LOCK_W     = 16,
  parameter int unsigned RELOCK_RST = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [DATA_W-1:0]  wr_data,
  output logic               sys_down_en,
  output logic [NUM_PLL-1:0] pll_off,
  output logic [NUM_OUT-1:0] out_off,
  output logic [NUM_PLL-1:0] susp_pll,
  output logic [NUM_OUT-1:0] susp_out,
  output logic [LOCK_W-1:0]  relock_n,
  output logic               err_clr
);

  function automatic logic hit(input logic [ADDR_W-1:0] a, input int unsigned r);
    return a == ADDR_W'(r);
  endfunction

  assign err_clr = wr_en && hit(wr_addr, ADR_CTRL) && wr_data[CTRL_ERRCLR];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sys_down_en <= 1'b0;
      pll_off     <= '0;
      out_off     <= '0;
      susp_pll    <= '0;
      susp_out    <= '0;
      relock_n    <= LOCK_W'(RELOCK_RST);
    end else if (wr_en) begin
      if (hit(wr_addr, ADR_CTRL))     sys_down_en <= wr_data[CTRL_SYSDOWN];
      if (hit(wr_addr, ADR_PLL_OFF))  pll_off     <= wr_data[NUM_PLL-1:0];
      if (hit(wr_addr, ADR_OUT_OFF))  out_off     <= wr_data[NUM_OUT-1:0];
      if (hit(wr_addr, ADR_SUSP_PLL)) susp_pll    <= wr_data[NUM_PLL-1:0];
      if (hit(wr_addr, ADR_SUSP_OUT)) susp_out    <= wr_data[NUM_OUT-1:0];
      if (hit(wr_addr, ADR_RELOCK))   relock_n    <= wr_data[LOCK_W-1:0];
    end
  end

  // R7
  relock_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && hit(wr_addr, ADR_RELOCK)) |=> (relock_n == $past(wr_data[LOCK_W-1:0])));

endmodule

// File: rtl/pwr_pll_lock.sv
module pwr_pll_lock
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned LOCK_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic [LOCK_W-1:0] relock_n,
  output logic              en,
  output logic              ready,
  output logic              ready_nxt
);

  lock_state_e       st_q, st_d;
  logic [LOCK_W-1:0] cnt_q, cnt_d;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    if (!run) begin
      st_d  = LK_OFF;
      cnt_d = '0;
    end else begin
      unique case (st_q)
        LK_OFF: begin
          cnt_d = relock_n;
          st_d  = (relock_n == '0) ? LK_READY : LK_WAIT;
        end
        LK_WAIT: begin
          if (cnt_q <= LOCK_W'(1)) begin
            cnt_d = '0;
            st_d  = LK_READY;
          end else begin
            cnt_d = cnt_q - LOCK_W'(1);
          end
        end
        LK_READY: cnt_d = '0;
        default: begin
          st_d  = LK_OFF;
          cnt_d = '0;
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= LK_OFF;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign en        = (st_q != LK_OFF);
  assign ready     = (st_q == LK_READY);
  assign ready_nxt = (st_d == LK_READY);

  // R4
  stop_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (!en && !ready));

  // R8
  start_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> en);

  // R8
  relock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !en && relock_n != '0) |=> !ready);

endmodule

// File: rtl/pwr_out_gate.sv
module pwr_out_gate #(
  parameter int unsigned NUM_PLL = 3,
  parameter int unsigned SRC_W   = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               shdn_oe_n,
  input  logic               susp_n,
  input  logic               off,
  input  logic               susp_mask,
  input  logic [SRC_W-1:0]   src,
  input  logic [NUM_PLL-1:0] pll_rdy_nxt,
  output logic               oe
);

  logic src_ok;
  logic oe_d;

  always_comb begin
    src_ok = (src == '0);
    for (int k = 0; k < NUM_PLL; k++) begin
      if (src == SRC_W'(k + 1)) src_ok = pll_rdy_nxt[k];
    end
  end

  assign oe_d = shdn_oe_n && !off && !(!susp_n && susp_mask) && src_ok;

  always_ff @(posedge clk) begin
    if (!rst_n) oe <= 1'b0;
    else        oe <= oe_d;
  end

  // R6
  out_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> !oe);

  // R4
  out_susp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!susp_n && susp_mask) |=> !oe);

endmodule

// File: rtl/pwr_suspend_ctrl.sv
module pwr_suspend_ctrl
  import pwr_ctl_pkg::*;
#(
  parameter int unsigned NUM_PLL    = 3,
  parameter int unsigned NUM_OUT    = 4,
  parameter int unsigned ADDR_W     = 3,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned LOCK_W     = 16,
  parameter int unsigned RELOCK_RST = 8,
  localparam int unsigned SRC_W     = $clog2(NUM_PLL + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     shdn_oe_n,
  input  logic                     susp_n,
  input  logic [NUM_OUT*SRC_W-1:0] route_sel,
  input  logic                     cfg_valid,
  output logic                     cfg_ready,
  input  logic [ADDR_W-1:0]        cfg_addr,
  input  logic [DATA_W-1:0]        cfg_wdata,
  output logic [NUM_PLL-1:0]       pll_en,
  output logic [NUM_PLL-1:0]       pll_ready,
  output logic [NUM_OUT-1:0]       out_oe,
  output logic                     osc_en,
  output logic                     div_en,
  output logic                     mask_err
);

  logic               sys_down_en;
  logic [NUM_PLL-1:0] pll_off, susp_pll, pll_run, pll_rdy_nxt;
  logic [NUM_OUT-1:0] out_off, susp_out;
  logic [LOCK_W-1:0]  relock_n;
  logic               err_clr, err_set, full_down;

  assign cfg_ready = 1'b1;
  assign full_down = !shdn_oe_n && sys_down_en;

  pwr_cfg_regs #(
    .NUM_PLL(NUM_PLL), .NUM_OUT(NUM_OUT), .ADDR_W(ADDR_W),
    .DATA_W(DATA_W), .LOCK_W(LOCK_W), .RELOCK_RST(RELOCK_RST)
  ) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en(cfg_valid && cfg_ready), .wr_addr(cfg_addr), .wr_data(cfg_wdata),
    .sys_down_en(sys_down_en), .pll_off(pll_off), .out_off(out_off),
    .susp_pll(susp_pll), .susp_out(susp_out), .relock_n(relock_n),
    .err_clr(err_clr)
  );

  for (genvar p = 0; p < NUM_PLL; p++) begin : g_pll
    assign pll_run[p] = !full_down && !pll_off[p] && !(!susp_n && susp_pll[p]);
    pwr_pll_lock #(.LOCK_W(LOCK_W)) u_lock (
      .clk(clk), .rst_n(rst_n), .run(pll_run[p]), .relock_n(relock_n),
      .en(pll_en[p]), .ready(pll_ready[p]), .ready_nxt(pll_rdy_nxt[p])
    );
  end

  for (genvar o = 0; o < NUM_OUT; o++) begin : g_out
    pwr_out_gate #(.NUM_PLL(NUM_PLL), .SRC_W(SRC_W)) u_gate (
      .clk(clk), .rst_n(rst_n), .shdn_oe_n(shdn_oe_n), .susp_n(susp_n),
      .off(out_off[o]), .susp_mask(susp_out[o]),
      .src(route_sel[o*SRC_W +: SRC_W]), .pll_rdy_nxt(pll_rdy_nxt),
      .oe(out_oe[o])
    );
    for (genvar k = 0; k < NUM_PLL; k++) begin : g_dep
      // R5
      dep_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (route_sel[o*SRC_W +: SRC_W] == SRC_W'(k + 1)) |=> (!out_oe[o] || pll_ready[k]));
    end
  end

  // Suspend mask consistency: a suspended PLL with an unmasked dependent output
  always_comb begin
    err_set = 1'b0;
    for (int o = 0; o < NUM_OUT; o++) begin
      for (int k = 0; k < NUM_PLL; k++) begin
        if (route_sel[o*SRC_W +: SRC_W] == SRC_W'(k + 1) && susp_pll[k] && !susp_out[o])
          err_set = 1'b1;
      end
    end
    if (susp_n) err_set = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mask_err <= 1'b0;
      osc_en   <= 1'b0;
      div_en   <= 1'b0;
    end else begin
      if (err_set)      mask_err <= 1'b1;
      else if (err_clr) mask_err <= 1'b0;
      osc_en <= !full_down;
      div_en <= !full_down;
    end
  end

  // R1
  oe_shdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_oe_n |=> (out_oe == '0));

  // R2
  sysdown_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!shdn_oe_n && sys_down_en) |=> (!osc_en && !div_en && pll_en == '0));

  // R9
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_set |=> mask_err);

  // R9
  err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_err && !err_clr) |=> mask_err);

endmodule

// File: tb/pwr_suspend_ctrl_test.sv
module pwr_suspend_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 3;
  localparam int NO = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        shdn_oe_n = 1'b1;
  logic        susp_n = 1'b1;
  logic [7:0]  route_sel = 8'h00;
  logic        cfg_valid = 1'b0;
  logic        cfg_ready;
  logic [2:0]  cfg_addr = 3'd0;
  logic [15:0] cfg_wdata = 16'h0;
  logic [2:0]  pll_en, pll_ready;
  logic [3:0]  out_oe;
  logic        osc_en, div_en, mask_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_suspend_ctrl uut (
    .clk(clk), .rst_n(rst_n), .shdn_oe_n(shdn_oe_n), .susp_n(susp_n),
    .route_sel(route_sel), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .pll_en(pll_en),
    .pll_ready(pll_ready), .out_oe(out_oe), .osc_en(osc_en),
    .div_en(div_en), .mask_err(mask_err)
  );

  // Behavioural reference model
  int m_sysdown, m_relock, m_err;
  int m_poff[NP], m_spll[NP], m_en[NP], m_cnt[NP], m_rdy[NP];
  int m_ooff[NO], m_sout[NO], m_oe[NO];
  int m_osc;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_sysdown = 0; m_relock = 8; m_err = 0; m_osc = 0;
      for (int i = 0; i < NP; i++) begin
        m_poff[i] = 0; m_spll[i] = 0; m_en[i] = 0; m_cnt[i] = 0; m_rdy[i] = 0;
      end
      for (int i = 0; i < NO; i++) begin
        m_ooff[i] = 0; m_sout[i] = 0; m_oe[i] = 0;
      end
    end else begin
      int full, bad;
      full = (!shdn_oe_n && m_sysdown != 0) ? 1 : 0;
      for (int p = 0; p < NP; p++) begin
        int run;
        run = (!full && !m_poff[p] && !(!susp_n && m_spll[p])) ? 1 : 0;
        if (!run) begin
          m_en[p] = 0; m_cnt[p] = 0;
        end else if (!m_en[p]) begin
          m_en[p] = 1; m_cnt[p] = m_relock;
        end else if (m_cnt[p] > 0) begin
          m_cnt[p]--;
        end
        m_rdy[p] = (run && m_cnt[p] == 0) ? 1 : 0;
      end
      bad = 0;
      for (int o = 0; o < NO; o++) begin
        int src, ok;
        src = int'(route_sel[o*2 +: 2]);
        ok = (src == 0) ? 1 : m_rdy[src-1];
        m_oe[o] = (shdn_oe_n && !m_ooff[o] && !(!susp_n && m_sout[o]) && ok) ? 1 : 0;
        if (!susp_n && src != 0 && m_spll[src-1] && !m_sout[o]) bad = 1;
      end
      if (bad) m_err = 1;
      else if (cfg_valid && cfg_addr == 3'd0 && cfg_wdata[1]) m_err = 0;
      m_osc = full ? 0 : 1;
      if (cfg_valid) begin
        case (cfg_addr)
          3'd0: m_sysdown = int'(cfg_wdata[0]);
          3'd1: for (int i = 0; i < NP; i++) m_poff[i] = int'(cfg_wdata[i]);
          3'd2: for (int i = 0; i < NO; i++) m_ooff[i] = int'(cfg_wdata[i]);
          3'd3: for (int i = 0; i < NP; i++) m_spll[i] = int'(cfg_wdata[i]);
          3'd4: for (int i = 0; i < NO; i++) m_sout[i] = int'(cfg_wdata[i]);
          3'd5: m_relock = int'(cfg_wdata);
          default: ;
        endcase
      end
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Cycle-by-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int p = 0; p < NP; p++) begin
        chk("R2/R3/R4/R6", $sformatf("pll_en[%0d]", p), int'(pll_en[p]), m_en[p]);
        chk("R8", $sformatf("pll_ready[%0d]", p), int'(pll_ready[p]), m_rdy[p]);
      end
      for (int o = 0; o < NO; o++)
        chk("R1/R5/R10", $sformatf("out_oe[%0d]", o), int'(out_oe[o]), m_oe[o]);
      chk("R2", "osc_en", int'(osc_en), m_osc);
      chk("R2", "div_en", int'(div_en), m_osc);
      chk("R9", "mask_err", int'(mask_err), m_err);
      chk("R7", "cfg_ready", int'(cfg_ready), 1);
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input int a, input int d);
    cfg_valid = 1'b1; cfg_addr = 3'(a); cfg_wdata = 16'(d);
    cyc(1);
    cfg_valid = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    route_sel = {2'd0, 2'd3, 2'd2, 2'd1};
    cyc(3);
    // R11 reset state
    chk("R11", "reset outputs", int'({pll_en, pll_ready, out_oe, osc_en, div_en, mask_err}), 0);
    rst_n = 1'b1;
    cyc(1);
    chk("R8", "pll_en after start", int'(pll_en), 7);
    chk("R8", "pll_ready during relock", int'(pll_ready), 0);
    chk("R10", "reference-routed output only", int'(out_oe), 4'b1000);
    cyc(8);
    chk("R8", "ready after default relock 8", int'(pll_ready), 7);
    chk("R8", "all outputs on", int'(out_oe), 4'hF);

    wr(5, 3);
    wr(1, 2);
    cyc(1);
    chk("R6", "pll1 disabled", int'(pll_en), 3'b101);
    chk("R5", "output of pll1 off", int'(out_oe), 4'b1101);
    wr(1, 0);
    cyc(1);
    chk("R8", "pll1 restarted", int'(pll_en), 7);
    chk("R8", "pll1 not ready", int'(pll_ready[1]), 0);
    cyc(2);
    chk("R8", "pll1 still not ready at 2", int'(pll_ready[1]), 0);
    chk("R8", "dependent output held", int'(out_oe[1]), 0);
    cyc(1);
    chk("R8", "pll1 ready after 3", int'(pll_ready[1]), 1);
    chk("R8", "dependent output on", int'(out_oe), 4'hF);

    wr(2, 8);
    cyc(1);
    chk("R6", "output 3 disabled", int'(out_oe), 4'b0111);
    wr(2, 0);

    shdn_oe_n = 1'b0;
    cyc(1);
    chk("R1", "outputs off in OE-low", int'(out_oe), 0);
    chk("R3", "plls keep running", int'(pll_en), 7);
    chk("R3", "oscillator on", int'(osc_en), 1);
    chk("R7", "cfg_ready in shutdown", int'(cfg_ready), 1);
    wr(5, 0);
    shdn_oe_n = 1'b1;
    cyc(1);
    chk("R1", "outputs back", int'(out_oe), 4'hF);

    wr(0, 1);
    shdn_oe_n = 1'b0;
    cyc(1);
    chk("R2", "plls stopped", int'(pll_en), 0);
    chk("R2", "osc/div stopped", int'({osc_en, div_en}), 0);
    shdn_oe_n = 1'b1;
    cyc(1);
    chk("R8", "relock 0 ready at once", int'(pll_ready), 7);
    chk("R2", "osc restarted", int'(osc_en), 1);
    wr(0, 0);

    wr(3, 1);
    wr(4, 1);
    cyc(1);
    chk("R4", "masks idle while suspend high", int'(out_oe), 4'hF);
    susp_n = 1'b0;
    cyc(1);
    chk("R4", "pll0 suspended", int'(pll_en), 3'b110);
    chk("R4", "output 0 suspended", int'(out_oe), 4'b1110);
    chk("R9", "no error when consistent", int'(mask_err), 0);
    wr(4, 0);
    cyc(1);
    chk("R5", "dependent output forced off", int'(out_oe), 4'b1110);
    chk("R9", "error set", int'(mask_err), 1);
    susp_n = 1'b1;
    cyc(1);
    chk("R9", "error sticky", int'(mask_err), 1);
    wr(0, 2);
    chk("R9", "error cleared", int'(mask_err), 0);
    susp_n = 1'b0;
    wr(0, 2);
    chk("R9", "set wins over clear", int'(mask_err), 1);
    route_sel[7:6] = 2'd1;
    cyc(1);
    chk("R5", "rerouted output follows suspended pll", int'(out_oe[3]), 0);
    susp_n = 1'b1;
    cyc(2);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule